// File: doc/BRIEF.md
# Sixteen-Bit Reload Timer with Compare Toggle and Baud Tick

This block is an up-counting 16-bit timer that sits on a byte-wide peripheral register bus. Two data addresses serve both a reload register and the live counter: byte writes land in the reload register and byte reads return the running count. A control byte holds the run enable, the clock source, a four-step prescaler, an operating mode and a compare enable. On each rollover the counter is refilled from the reload register.

In the plain timer mode a rollover sets a sticky overflow flag. The flag drives an interrupt request through an external enable. With compare enabled and the system clock selected, a rollover also inverts a pin output. In the baud mode a rollover emits a one-cycle tick for a serial port and leaves the flag alone. The tick rate is the prescaled clock divided by (65536 minus the reload value). The edge-triggered mode is kept only as a reserved encoding, and in that encoding the counter holds.

Top module: `reload_timer16`

## Requirements
- R1: After reset the control byte reads 0x00, the counter and reload register are 0x0000, and irq_req, cmp_pin_out and baud_tick are 0.
- R2: Control bit 1 (run) lets the counter advance by one per prescaled tick. Clearing it freezes the count, and setting it again does not clear the count.
- R3: In mode 00 (timer), a tick taken at 0xFFFF loads the reload value into the counter and sets control bit 7 (overflow flag) on the same edge.
- R4: A write to address 1 stores the low reload byte and leaves the counter alone. A write to address 2 stores the high reload byte and at once loads the counter with {written byte, low reload byte}.
- R5: A read of address 2 returns the counter's high byte and captures its low byte into a shadow. A read of address 1 returns that shadow, so a high-then-low read pair gives one coherent 16-bit value. Address 0 reads the control byte.
- R6: Control bits 3:2 divide the count source by 1 (00), 8 (01), 64 (10) or 256 (11). The divider restarts whenever counting is off.
- R7: Control bit 0 at 1 counts rising edges of ext_pin_in after a two-flop synchronizer. At 0 it counts every system clock.
- R8: Control bits 5:4 = 01 (baud) reload on rollover and pulse baud_tick for one cycle, in the cycle after the rollover edge. They never set the overflow flag.
- R9: Control bits 5:4 = 10 or 11 are reserved, and in them the counter holds even with run set.
- R10: With control bit 6 (compare) set, mode 00 and bit 0 at 0, cmp_pin_out inverts on every rollover. It does not change under any other setting.
- R11: irq_req equals the overflow flag ANDed with irq_en. Writing 0 to control bit 7 clears the flag, and writing 1 leaves it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 control, 1 low data, 2 high data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| ext_pin_in | input | 1 | External count input, asynchronous |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| irq_req | output | 1 | Interrupt request |
| cmp_pin_out | output | 1 | Compare toggle output |
| baud_tick | output | 1 | One-cycle pulse per rollover in baud mode |

## Verification
A table of runs sets a reload value, a divider and a mode, runs the timer for a chosen number of cycles and stops it. The final count shows whether the divider is right, and whether the refill comes from the reload value rather than from zero when the window crosses 0xFFFF. The flag read after each run separates the timer mode from the baud and reserved modes. Directed cases then cover the remaining behaviour. They pulse the external pin to tell edge counting apart from level counting, and they start a running count and read it to show that the shadow captured on the high-byte read is returned, not the live low byte. They also show that compare toggles the pin only when the system clock is the count source, and that writes of 0 and 1 to the flag bit behave differently.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = 2 * BYTE_W;
    localparam int unsigned PRE_W  = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_BAUD  = 2'b01,
        MODE_EDGE  = 2'b10,
        MODE_RSVD  = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        DIV_1   = 2'b00,
        DIV_8   = 2'b01,
        DIV_64  = 2'b10,
        DIV_256 = 2'b11
    } tmr_div_e;

    // control byte layout, msb first
    typedef struct packed {
        logic      flag;
        logic      cmp_en;
        tmr_mode_e mode;
        tmr_div_e  div;
        logic      run;
        logic      ext_sel;
    } tmr_ctrl_t;

    function automatic logic [PRE_W-1:0] div_last(input tmr_div_e d);
        case (d)
            DIV_1:   return PRE_W'(0);
            DIV_8:   return PRE_W'(7);
            DIV_64:  return PRE_W'(63);
            default: return PRE_W'(255);
        endcase
    endfunction

    function automatic logic mode_counts(input tmr_mode_e m);
        return (m == MODE_TIMER) || (m == MODE_BAUD);
    endfunction

endpackage

// File: rtl/rt_edge_sync.sv
module rt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[DEPTH-2:0], din};
    end

    assign rise = pipe[DEPTH-2] & ~pipe[DEPTH-1];

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler
    import rt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     step,
    input  tmr_div_e div,
    output logic     tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] last;

    assign last = div_last(div);
    assign tick = enable && step && (pre_cnt >= last);

    always_ff @(posedge clk) begin
        if (rst || !enable)  pre_cnt <= '0;
        else if (tick)       pre_cnt <= '0;
        else if (step)       pre_cnt <= pre_cnt + 1'b1;
    end

    a_r6_idle_restart: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (pre_cnt == '0));
    a_r6_hold_without_step: assert property (@(posedge clk) disable iff (rst)
        (enable && !step) |=> $stable(pre_cnt));

endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         force_load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = inc && (&cnt) && !force_load;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (force_load) cnt <= load_val;
        else if (wrap)       cnt <= load_val;
        else if (inc)        cnt <= cnt + 1'b1;
    end

    a_r3_refill: assert property (@(posedge clk) disable iff (rst)
        (inc && (&cnt) && !force_load) |=> (cnt == $past(load_val)));
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !(&cnt) && !force_load) |=> (cnt == $past(cnt) + 1'b1));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!inc && !force_load) |=> $stable(cnt));
    a_r4_force: assert property (@(posedge clk) disable iff (rst)
        force_load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
    import rt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ext_pin_in,
    input  logic       irq_en,
    output logic       irq_req,
    output logic       cmp_pin_out,
    output logic       baud_tick
);
    tmr_ctrl_t         ctrl;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shadow_lo;
    logic              ctrl_wr, lo_wr, hi_wr, hi_rd;
    logic              ext_rise, src_step, count_on, inc, wrap, flag_set;
    logic              cmp_pin_q, baud_q;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign lo_wr   = bus_wr && (bus_addr == ADDR_LO);
    assign hi_wr   = bus_wr && (bus_addr == ADDR_HI);
    assign hi_rd   = bus_rd && (bus_addr == ADDR_HI);

    assign count_on = ctrl.run && mode_counts(ctrl.mode);
    assign src_step = ctrl.ext_sel ? ext_rise : 1'b1;
    assign load_val = hi_wr ? {bus_wdata, reload_q[BYTE_W-1:0]} : reload_q;
    assign flag_set = wrap && (ctrl.mode == MODE_TIMER);

    rt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_pin_in),
        .rise (ext_rise)
    );

    rt_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .enable (count_on),
        .step   (src_step),
        .div    (ctrl.div),
        .tick   (inc)
    );

    rt_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .inc        (inc),
        .force_load (hi_wr),
        .load_val   (load_val),
        .cnt        (cnt),
        .wrap       (wrap)
    );

    // control byte: flag is sticky, software may only clear it
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl.cmp_en  <= bus_wdata[6];
                ctrl.mode    <= tmr_mode_e'(bus_wdata[5:4]);
                ctrl.div     <= tmr_div_e'(bus_wdata[3:2]);
                ctrl.run     <= bus_wdata[1];
                ctrl.ext_sel <= bus_wdata[0];
            end
            if (flag_set)                    ctrl.flag <= 1'b1;
            else if (ctrl_wr && !bus_wdata[7]) ctrl.flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else begin
            if (lo_wr) reload_q[BYTE_W-1:0]      <= bus_wdata;
            if (hi_wr) reload_q[CNT_W-1:BYTE_W]  <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        shadow_lo <= '0;
        else if (hi_rd) shadow_lo <= cnt[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_pin_q <= 1'b0;
            baud_q    <= 1'b0;
        end else begin
            baud_q <= wrap && (ctrl.mode == MODE_BAUD);
            if (wrap && ctrl.cmp_en && !ctrl.ext_sel && (ctrl.mode == MODE_TIMER))
                cmp_pin_q <= ~cmp_pin_q;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl;
            ADDR_LO:   bus_rdata = shadow_lo;
            ADDR_HI:   bus_rdata = cnt[CNT_W-1:BYTE_W];
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_req     = ctrl.flag && irq_en;
    assign cmp_pin_out = cmp_pin_q;
    assign baud_tick   = baud_q;

    a_r8_baud_no_flag: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_BAUD && !ctrl.flag && !ctrl_wr) |=> !ctrl.flag);
    a_r9_reserved_hold: assert property (@(posedge clk) disable iff (rst)
        (!mode_counts(ctrl.mode) && !hi_wr) |=> $stable(cnt));
    a_r10_pin_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (cmp_pin_q != $past(cmp_pin_q)) |-> $past(wrap && !ctrl.ext_sel));
    a_r11_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !bus_wdata[7] && !wrap) |=> !ctrl.flag);
    a_r8_tick_single: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> $past(ctrl.mode == MODE_BAUD));

endmodule

// File: tb/reload_timer16_tb.sv
module reload_timer16_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_pin_in = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq_req, cmp_pin_out, baud_tick;

    int n_run = 0;
    int n_fail = 0;
    int tick_seen = 0;

    always #2.5 clk = ~clk;

    reload_timer16 u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pin_in(ext_pin_in), .irq_en(irq_en), .irq_req(irq_req),
        .cmp_pin_out(cmp_pin_out), .baud_tick(baud_tick)
    );

    always @(negedge clk) if (!rst && baud_tick) tick_seen++;

    // {div[1:0], mode[1:0], idle cycles[9:0], reload[15:0]}
    localparam logic [29:0] VEC [8] = '{
        {2'b00, 2'b00, 10'd10,  16'h1234},
        {2'b01, 2'b00, 10'd38,  16'h0100},
        {2'b10, 2'b00, 10'd254, 16'hABCD},
        {2'b11, 2'b00, 10'd510, 16'h0000},
        {2'b00, 2'b00, 10'd30,  16'hFFF0},
        {2'b00, 2'b01, 10'd30,  16'hFFF0},
        {2'b01, 2'b00, 10'd14,  16'hFFFE},
        {2'b00, 2'b10, 10'd10,  16'h4444}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h, l;
        rd(2'd2, h);
        rd(2'd1, l);
        v = {h, l};
    endtask

    task automatic set_reload(input logic [15:0] v);
        wr(2'd1, v[7:0]);
        wr(2'd2, v[15:8]);
    endtask

    function automatic logic [15:0] model(input logic [15:0] ld, input int n,
                                         output int wraps);
        logic [15:0] c = ld;
        wraps = 0;
        for (int i = 0; i < n; i++) begin
            if (c == 16'hFFFF) begin c = ld; wraps++; end
            else c = c + 1'b1;
        end
        return c;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        logic        pin_before;
        int          t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, b);   chk(b == 8'h00, "R1 ctrl", b, 0);
        rd16(v);       chk(v == 16'h0000, "R1 counter", v, 0);
        chk(!irq_req && !cmp_pin_out && !baud_tick, "R1 outputs",
            {irq_req, cmp_pin_out, baud_tick}, 0);

        // table of runs: R2 R3 R6 R8 R9
        for (int i = 0; i < 8; i++) begin
            logic [1:0]  dv   = VEC[i][29:28];
            logic [1:0]  md   = VEC[i][27:26];
            int          idle = int'(VEC[i][25:16]);
            logic [15:0] ld   = VEC[i][15:0];
            int          divn = (dv == 0) ? 1 : (dv == 1) ? 8 : (dv == 2) ? 64 : 256;
            int          incs = (md[1]) ? 0 : (idle + 2) / divn;
            int          wraps;
            logic [15:0] exp_c = model(ld, incs, wraps);
            wr(2'd0, 8'h00);
            set_reload(ld);
            t0 = tick_seen;
            wr(2'd0, {2'b00, md, dv, 2'b10});
            repeat (idle) @(negedge clk);
            wr(2'd0, {2'b10, md, dv, 2'b00});
            repeat (3) @(negedge clk);
            rd16(v);
            chk(v == exp_c, $sformatf("R2 R6 R3 R9 count vec%0d", i), v, exp_c);
            rd(2'd0, b);
            chk(b[7] == (wraps > 0 && md == 2'b00), $sformatf("R3 R8 flag vec%0d", i),
                b[7], (wraps > 0 && md == 2'b00));
            if (md == 2'b01)
                chk(tick_seen - t0 == wraps, "R8 tick count", tick_seen - t0, wraps);
        end

        // R2: restart continues from held value
        wr(2'd0, 8'h00);
        set_reload(16'h0200);
        wr(2'd0, 8'h02); repeat (3) @(negedge clk); wr(2'd0, 8'h80);
        wr(2'd0, 8'h02); repeat (3) @(negedge clk); wr(2'd0, 8'h80);
        rd16(v); chk(v == 16'h020A, "R2 resume", v, 16'h020A);

        // R4 low write alone, then high write reload
        wr(2'd1, 8'h55);
        rd16(v); chk(v == 16'h020A, "R4 low write no reload", v, 16'h020A);
        wr(2'd2, 8'h20);
        rd16(v); chk(v == 16'h2055, "R4 high write reload", v, 16'h2055);

        // R5 coherent read while running
        wr(2'd0, 8'h00);
        set_reload(16'h12FC);
        wr(2'd0, 8'h02);
        rd(2'd2, b); chk(b == 8'h12, "R5 high byte", b, 8'h12);
        wr(2'd0, 8'h80);
        rd(2'd1, b); chk(b == 8'hFD, "R5 shadow low", b, 8'hFD);

        // R8 baud rate: reload FFFF, div 8, 40 source cycles -> 5 ticks
        wr(2'd0, 8'h00);
        set_reload(16'hFFFF);
        t0 = tick_seen;
        wr(2'd0, 8'h16); repeat (38) @(negedge clk); wr(2'd0, 8'h94);
        repeat (3) @(negedge clk);
        chk(tick_seen - t0 == 5, "R8 baud rate", tick_seen - t0, 5);
        chk(!irq_req, "R8 no irq", irq_req, 0);

        // R7 external edges
        wr(2'd0, 8'h00);
        set_reload(16'h0010);
        wr(2'd0, 8'h03);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk) ext_pin_in = 1'b1; repeat (4) @(negedge clk);
            ext_pin_in = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(2'd0, 8'h81);
        rd16(v); chk(v == 16'h0015, "R7 ext edges", v, 16'h0015);

        // R10 compare toggle, R11 irq and flag
        wr(2'd0, 8'h00);
        set_reload(16'hFFFE);
        wr(2'd0, 8'h42); wr(2'd0, 8'hC0);
        chk(cmp_pin_out == 1'b1, "R10 toggle", cmp_pin_out, 1);
        rd16(v); chk(v == 16'hFFFE, "R3 refill", v, 16'hFFFE);
        irq_en = 1'b1; #1;
        chk(irq_req == 1'b1, "R11 irq on", irq_req, 1);
        irq_en = 1'b0; #1;
        chk(irq_req == 1'b0, "R11 irq masked", irq_req, 0);
        wr(2'd0, 8'h40); rd(2'd0, b);
        chk(b == 8'h40, "R11 clear", b, 8'h40);
        wr(2'd0, 8'h80); rd(2'd0, b);
        chk(b == 8'h00, "R11 write one no set", b, 8'h00);

        // R10 compare ignored with external source
        set_reload(16'hFFFE);
        pin_before = cmp_pin_out;
        wr(2'd0, 8'h43);
        for (int p = 0; p < 2; p++) begin
            @(negedge clk) ext_pin_in = 1'b1; repeat (4) @(negedge clk);
            ext_pin_in = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(2'd0, 8'hC1);
        chk(cmp_pin_out == pin_before, "R10 no toggle ext", cmp_pin_out, pin_before);
        rd(2'd0, b); chk(b == 8'hC1, "R3 flag ext wrap", b, 8'hC1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule